// File: doc/BRIEF.md
# ALU Flag and Decimal-Adjust Unit

This block is the arithmetic and condition-code stage of an 8-bit accumulator datapath. Each cycle it may take one operation code, two operands, a 16-bit value (used only by the wide load/store operation) and the current condition flags. One clock later it presents the 8-bit result and the updated flags, registered. The operations are:

- addition with and without carry-in
- subtraction with and without borrow-in
- the three bitwise logic operations
- 8-bit and 16-bit load/store flag updates
- four shift and rotate operations
- a decimal-adjust step

The surrounding core keeps the flag register. It feeds the flags back in with the next operation. The decimal adjust uses the half-carry and carry left by a previous addition of two packed-BCD bytes and turns the binary sum into a valid two-digit BCD value.

The flags travel as a 5-bit vector: bit 4 overflow (V), bit 3 half-carry (H), bit 2 negative (N), bit 1 zero (Z), bit 0 carry/borrow (C).

Top module: `alu_flag_unit`

## Requirements
- R1: Op code 0 (add) gives A+B and op code 1 (add with carry) gives A+B+C_in, both modulo 256. C is set exactly when the sum carries out of bit 7.
- R2: For op codes 0 and 1, H is set when the low nibbles plus carry-in carry into bit 4, and cleared otherwise. All other operations except these two leave H at its input value.
- R3: For addition, V is set when A and B share a sign bit and the result's sign differs. For subtraction, V is set when A and B differ in sign and the result's sign differs from A.
- R4: Op code 2 (subtract) gives A-B and op code 3 (subtract with borrow) gives A-B-C_in, both modulo 256. C is set exactly when a borrow is needed.
- R5: For every operation with an 8-bit result (op codes 0–7 and 9–13), N equals result bit 7 and Z is set exactly when the result is 0x00.
- R6: Op codes 4 (AND), 5 (OR) and 6 (XOR) give the bitwise result of A and B. They clear V and leave H and C at their input values.
- R7: Op code 7 (8-bit load/store) passes B to the result. Op code 8 (16-bit load/store) outputs the low byte of the wide value, takes N from its bit 15, and sets Z only when all 16 bits are zero. Both op codes clear V and keep H and C.
- R8: The shift and rotate op codes, with C set to the bit shifted out and V = N xor C (new values), are:
  - 9: shift left, zero in, C gets bit 7.
  - 10: logical shift right, zero in, C gets bit 0.
  - 11: rotate left through C.
  - 12: rotate right through C.
- R9: Op code 13 (decimal adjust) applies its corrections to A modulo 256:
  - It adds 0x06 when H is set or A's low nibble exceeds 9.
  - It adds 0x60 when C is set or A exceeds 0x99.
  - C becomes set if the 0x60 correction applies and is never cleared.
  - V and H are kept.
- R10: Result, flags and valid are registered. An operation accepted with op_valid high appears with res_valid high one clock later. With op_valid low, res_valid drops and result and flags hold, whatever the other inputs do.
- R11: While rst_n is low at a clock edge, result, flags and res_valid become zero.
- R12: Op codes 14 and 15 pass A to the result and return the input flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select (see requirements) |
| opnd_a | input | 8 | Accumulator operand / shift source |
| opnd_b | input | 8 | Second operand / 8-bit load value |
| wide_val | input | 16 | Value for 16-bit load/store flag update |
| flags_in | input | 5 | Current flags {V,H,N,Z,C} |
| result_o | output | 8 | Registered result |
| flags_o | output | 5 | Registered updated flags {V,H,N,Z,C} |
| res_valid_o | output | 1 | Result and flags belong to last accepted operation |

## Verification
The only state is the output register, so any wrong internal decision shows at the ports exactly one clock after the operation is accepted. There is no later cycle where it could surface first. A wrong carry or half-carry decision does its main damage downstream, because the core feeds these flags back into add-with-carry, subtract-with-borrow, rotates and decimal adjust. The bench therefore drives the returned flags as inputs with every combination that matters and compares each result and flag vector against an independent model on the very next cycle. Addition is swept over every operand pair, and decimal adjust over every accumulator value with all four H/C combinations.

// File: rtl/alu_flag_pkg.sv
// Shared types for the ALU flag unit: operation codes and flag layout.
// Assumes a 5-bit flag vector ordered {V,H,N,Z,C} from bit 4 down to bit 0.
package alu_flag_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_LD8  = 4'd7,
        OP_LD16 = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10,
        OP_ROL  = 4'd11,
        OP_ROR  = 4'd12,
        OP_DADJ = 4'd13
    } alu_op_e;

    localparam int FLAG_W = 5;

    typedef struct packed {
        logic v;
        logic h;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;

    // True for defined op codes whose N and Z derive from the 8-bit result.
    function automatic logic is_res8_op(input logic [3:0] code);
        return (code <= 4'd7) || ((code >= 4'd9) && (code <= 4'd13));
    endfunction

endpackage

// File: rtl/alu_arith.sv
// Adder/subtractor producing sum, carry/borrow, half-carry and overflow.
// Assumes DATA_W is even; half-carry is taken from the lower half boundary.
// H output is meaningful only for addition; the caller ignores it otherwise.
module alu_arith #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              c_out,
    output logic              h_out,
    output logic              v_out
);
    localparam int HALF_W = DATA_W / 2;
    localparam int MSB    = DATA_W - 1;

    logic [DATA_W:0] full;
    logic [HALF_W:0] low;

    // Form the wide sum or difference and the lower-half carry.
    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
            low  = '0;
        end else begin
            full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
            low  = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, cin};
        end
    end

    assign sum   = full[MSB:0];
    assign c_out = full[DATA_W];
    assign h_out = low[HALF_W];

    // Signed overflow: operand-sign relation depends on add versus subtract.
    always_comb begin
        if (sub)
            v_out = (a[MSB] != b[MSB]) && (full[MSB] != a[MSB]);
        else
            v_out = (a[MSB] == b[MSB]) && (full[MSB] != a[MSB]);
    end

endmodule

// File: rtl/alu_bitops.sv
// Bitwise logic, shifts and rotates with the carry they produce.
// Logic operations pass carry-in through; shifts return the bit shifted out.
module alu_bitops
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              c_out
);
    localparam int MSB = DATA_W - 1;

    // Select the bit operation and its carry.
    always_comb begin
        res   = a;
        c_out = cin;
        case (sel)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_SHL: begin res = {a[MSB-1:0], 1'b0}; c_out = a[MSB]; end
            OP_SHR: begin res = {1'b0, a[MSB:1]};   c_out = a[0];   end
            OP_ROL: begin res = {a[MSB-1:0], cin};  c_out = a[MSB]; end
            OP_ROR: begin res = {cin, a[MSB:1]};    c_out = a[0];   end
            default: begin res = a; c_out = cin; end
        endcase
    end

endmodule

// File: rtl/alu_decadj.sv
// Decimal adjust of a binary sum of two packed-BCD bytes (two digits).
// Assumes H and C are the flags left by the preceding addition.
module alu_decadj (
    input  logic [7:0] a,
    input  logic       h_in,
    input  logic       c_in,
    output logic [7:0] res,
    output logic       c_out
);
    logic       lo_fix;
    logic       hi_fix;
    logic [7:0] corr;

    // Decide which digit corrections apply.
    always_comb begin
        lo_fix = h_in || (a[3:0] > 4'd9);
        hi_fix = c_in || (a > 8'h99);
        corr   = {1'b0, hi_fix, hi_fix, 1'b0, 1'b0, lo_fix, lo_fix, 1'b0};
    end

    assign res   = a + corr;
    assign c_out = c_in | hi_fix;

endmodule

// File: rtl/alu_flag_unit.sv
// Top of the ALU flag unit: selects the operation, derives N/Z/V/H/C and
// registers result and flags one cycle after op_valid.
// Assumes the caller feeds back flags_o (or its own flag state) on flags_in.
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [3:0]            op_code,
    input  logic [DATA_W-1:0]     opnd_a,
    input  logic [DATA_W-1:0]     opnd_b,
    input  logic [2*DATA_W-1:0]   wide_val,
    input  logic [FLAG_W-1:0]     flags_in,
    output logic [DATA_W-1:0]     result_o,
    output logic [FLAG_W-1:0]     flags_o,
    output logic                  res_valid_o
);
    localparam int MSB  = DATA_W - 1;
    localparam int WMSB = 2 * DATA_W - 1;

    alu_op_e     op_e;
    alu_flags_t  cur_f;
    alu_flags_t  nx_f;
    logic [MSB:0] nx_res;

    logic         is_sub;
    logic         ar_cin;
    logic [MSB:0] ar_sum;
    logic         ar_c, ar_h, ar_v;
    logic [MSB:0] bo_res;
    logic         bo_c;
    logic [MSB:0] da_res;
    logic         da_c;

    logic [MSB:0] res_q;
    alu_flags_t   flags_q;
    logic         valid_q;

    assign op_e  = alu_op_e'(op_code);
    assign cur_f = flags_in;

    // Arithmetic direction and carry-in selection.
    always_comb begin
        is_sub = (op_e == OP_SUB) || (op_e == OP_SBC);
        ar_cin = ((op_e == OP_ADC) || (op_e == OP_SBC)) && cur_f.c;
    end

    alu_arith #(.DATA_W(DATA_W)) u_arith (
        .a(opnd_a), .b(opnd_b), .cin(ar_cin), .sub(is_sub),
        .sum(ar_sum), .c_out(ar_c), .h_out(ar_h), .v_out(ar_v)
    );

    alu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .sel(op_e), .a(opnd_a), .b(opnd_b), .cin(cur_f.c),
        .res(bo_res), .c_out(bo_c)
    );

    generate
        if (DATA_W == 8) begin : g_decadj
            alu_decadj u_decadj (
                .a(opnd_a), .h_in(cur_f.h), .c_in(cur_f.c),
                .res(da_res), .c_out(da_c)
            );
        end else begin : g_no_decadj
            assign da_res = opnd_a;
            assign da_c   = cur_f.c;
        end
    endgenerate

    // Merge per-operation result and flag updates.
    always_comb begin
        nx_res = opnd_a;
        nx_f   = cur_f;
        case (op_e)
            OP_ADD, OP_ADC: begin
                nx_res = ar_sum;
                nx_f.c = ar_c;
                nx_f.h = ar_h;
                nx_f.v = ar_v;
            end
            OP_SUB, OP_SBC: begin
                nx_res = ar_sum;
                nx_f.c = ar_c;
                nx_f.v = ar_v;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nx_res = bo_res;
                nx_f.v = 1'b0;
            end
            OP_LD8: begin
                nx_res = opnd_b;
                nx_f.v = 1'b0;
            end
            OP_LD16: begin
                nx_res = wide_val[MSB:0];
                nx_f.v = 1'b0;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                nx_res = bo_res;
                nx_f.c = bo_c;
                nx_f.v = bo_res[MSB] ^ bo_c;
            end
            OP_DADJ: begin
                nx_res = da_res;
                nx_f.c = da_c;
            end
            default: begin
                nx_res = opnd_a;
                nx_f   = cur_f;
            end
        endcase
        if (op_e == OP_LD16) begin
            nx_f.n = wide_val[WMSB];
            nx_f.z = (wide_val == '0);
        end else if (is_res8_op(op_code)) begin
            nx_f.n = nx_res[MSB];
            nx_f.z = (nx_res == '0);
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= op_valid;
            if (op_valid) begin
                res_q   <= nx_res;
                flags_q <= nx_f;
            end
        end
    end

    assign result_o    = res_q;
    assign flags_o     = flags_q;
    assign res_valid_o = valid_q;

    // R10: valid follows op_valid by one cycle.
    assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid_o);
    // R10: idle cycle holds outputs.
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid_o && $stable(result_o) && $stable(flags_o)));
    // R6: logic ops clear V and keep H and C.
    assert_logic_keeps_hc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code >= 4'd4) && (op_code <= 4'd6)) |=>
        (!flags_o[4] && flags_o[3] == $past(flags_in[3]) && flags_o[0] == $past(flags_in[0])));
    // R9: decimal adjust never clears carry.
    assert_dadj_keeps_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd13 && flags_in[0]) |=> flags_o[0]);
    // R5: N and Z agree with the registered 8-bit result.
    assert_nz_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_res8_op(op_code)) |=>
        (flags_o[1] == (result_o == '0) && flags_o[2] == result_o[MSB]));
    // R7: wide load takes Z from all sixteen bits.
    assert_wide_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd8) |=> (flags_o[1] == ($past(wide_val) == '0)));
    // R12: undefined codes return flags unchanged.
    assert_undef_passthru_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd14) |=> (flags_o == $past(flags_in) && result_o == $past(opnd_a)));

endmodule

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [7:0]  opnd_a = '0;
    logic [7:0]  opnd_b = '0;
    logic [15:0] wide_val = '0;
    logic [4:0]  flags_in = '0;
    logic [7:0]  result_o;
    logic [4:0]  flags_o;
    logic        res_valid_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic        pend = 0;
    logic [12:0] exp_q;
    string       tag_q;

    always #4 clk = ~clk;

    alu_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .wide_val(wide_val),
        .flags_in(flags_in), .result_o(result_o), .flags_o(flags_o),
        .res_valid_o(res_valid_o)
    );

    // Reference model: returns {result, V,H,N,Z,C}.
    function automatic logic [12:0] ref_alu(input logic [3:0] op, input logic [7:0] a,
                                            input logic [7:0] b, input logic [15:0] w,
                                            input logic [4:0] f);
        logic v = f[4], h = f[3], n = f[2], z = f[1], c = f[0];
        logic ci = f[0];
        logic [7:0] r = a;
        int s;
        int corr;
        case (op)
            4'd0, 4'd1: begin
                s = int'(a) + int'(b) + ((op == 4'd1 && ci) ? 1 : 0);
                r = s[7:0];
                h = (int'(a[3:0]) + int'(b[3:0]) + ((op == 4'd1 && ci) ? 1 : 0)) > 15;
                c = s > 255;
                v = (a[7] == b[7]) && (r[7] != a[7]);
            end
            4'd2, 4'd3: begin
                s = int'(a) - int'(b) - ((op == 4'd3 && ci) ? 1 : 0);
                r = s[7:0];
                c = s < 0;
                v = (a[7] != b[7]) && (r[7] != a[7]);
            end
            4'd4: begin r = a & b; v = 0; end
            4'd5: begin r = a | b; v = 0; end
            4'd6: begin r = a ^ b; v = 0; end
            4'd7: begin r = b; v = 0; end
            4'd8: return {w[7:0], 1'b0, h, w[15], (w == 16'h0), c};
            4'd9:  begin r = {a[6:0], 1'b0}; c = a[7]; v = r[7] ^ c; end
            4'd10: begin r = {1'b0, a[7:1]}; c = a[0]; v = r[7] ^ c; end
            4'd11: begin r = {a[6:0], ci};   c = a[7]; v = r[7] ^ c; end
            4'd12: begin r = {ci, a[7:1]};   c = a[0]; v = r[7] ^ c; end
            4'd13: begin
                corr = 0;
                if (h || a[3:0] > 4'd9) corr += 6;
                if (ci || a > 8'h99) begin corr += 96; c = 1; end
                s = int'(a) + corr;
                r = s[7:0];
            end
            default: return {a, f};
        endcase
        n = r[7];
        z = (r == 8'h00);
        return {r, v, h, n, z, c};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R1 R2 R3 R5";
            4'd2, 4'd3: return "R4 R3 R5";
            4'd4, 4'd5, 4'd6: return "R6 R5";
            4'd7, 4'd8: return "R7";
            4'd9, 4'd10, 4'd11, 4'd12: return "R8 R5";
            4'd13: return "R9 R5";
            default: return "R12";
        endcase
    endfunction

    // Compare the outputs against the previously issued operation.
    task automatic check_pending();
        if (pend) begin
            checks++;
            if (res_valid_o !== 1'b1 || {result_o, flags_o} !== exp_q) begin
                errors++;
                $display("FAIL %s (R10 valid=%b): got res=%h flags=%b exp res=%h flags=%b",
                         tag_q, res_valid_o, result_o, flags_o, exp_q[12:5], exp_q[4:0]);
            end
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] w, input logic [4:0] f);
        @(negedge clk);
        check_pending();
        op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b; wide_val = w; flags_in = f;
        exp_q = ref_alu(op, a, b, w, f);
        tag_q = tag_of(op);
        pend  = 1'b1;
    endtask

    // R10: two idle cycles with changing inputs must hold outputs.
    task automatic idle_check();
        logic [12:0] held;
        @(negedge clk);
        check_pending();
        pend = 1'b0;
        held = {result_o, flags_o};
        op_valid = 1'b0; op_code = 4'd0; opnd_a = 8'hFF; opnd_b = 8'hFF; flags_in = 5'h1F;
        @(negedge clk);
        op_code = 4'd13; opnd_a = 8'h5A;
        @(negedge clk);
        checks++;
        if (res_valid_o !== 1'b0 || {result_o, flags_o} !== held) begin
            errors++;
            $display("FAIL R10 idle hold: got v=%b %h expected v=0 %h",
                     res_valid_o, {result_o, flags_o}, held);
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired (all requirements)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd13579));
        // R11: reset state while an operation is presented.
        op_valid = 1'b1; op_code = 4'd0; opnd_a = 8'h12; opnd_b = 8'h34; flags_in = 5'h1F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (res_valid_o !== 1'b0 || result_o !== 8'h00 || flags_o !== 5'h00) begin
            errors++;
            $display("FAIL R11 reset: got v=%b res=%h flags=%b expected 0 00 00000",
                     res_valid_o, result_o, flags_o);
        end
        op_valid = 1'b0;
        rst_n = 1'b1;

        // Directed corners (R1 R2 R3 R4 R7 R8 R9 R12).
        issue(4'd0, 8'h7F, 8'h01, 16'h0, 5'h00);   // overflow and half-carry
        issue(4'd0, 8'h80, 8'h80, 16'h0, 5'h00);   // carry, overflow, zero
        issue(4'd1, 8'hFF, 8'h00, 16'h0, 5'h01);   // carry-in wraps to zero
        issue(4'd2, 8'h80, 8'h01, 16'h0, 5'h00);   // subtract overflow
        issue(4'd3, 8'h00, 8'h00, 16'h0, 5'h01);   // borrow-in forces borrow
        issue(4'd8, 8'h00, 8'h00, 16'h0000, 5'h09);// wide zero
        issue(4'd8, 8'h00, 8'h00, 16'h8000, 5'h00);// wide negative, low byte zero
        issue(4'd7, 8'h00, 8'h80, 16'h0, 5'h1F);
        issue(4'd11, 8'h80, 8'h00, 16'h0, 5'h00);  // rotate out to carry, zero
        issue(4'd12, 8'h01, 8'h00, 16'h0, 5'h01);
        issue(4'd13, 8'h9A, 8'h00, 16'h0, 5'h00);  // both corrections
        issue(4'd13, 8'h00, 8'h00, 16'h0, 5'h09);  // H and C forced
        issue(4'd14, 8'h3C, 8'h00, 16'h0, 5'h15);
        issue(4'd15, 8'h00, 8'hFF, 16'h0, 5'h0A);
        idle_check();

        // R1 R2 R3: every operand pair for addition, carry-in random.
        for (int i = 0; i < 65536; i++)
            issue(($urandom & 1) ? 4'd1 : 4'd0, i[15:8], i[7:0], 16'h0, 5'($urandom));
        idle_check();

        // R9: decimal adjust over all accumulator values and H/C pairs.
        for (int i = 0; i < 1024; i++)
            issue(4'd13, i[7:0], 8'h00, 16'h0, {1'b0, i[8], 2'b00, i[9]} | {1'($urandom), 1'b0, 2'($urandom), 1'b0});

        // Random mix of all op codes, including undefined ones (R12).
        for (int i = 0; i < 30000; i++) begin
            issue(4'($urandom), 8'($urandom), 8'($urandom),
                  (($urandom & 7) == 0) ? 16'h0 : 16'($urandom), 5'($urandom));
            if ((i % 5000) == 4999) idle_check();
        end
        @(negedge clk);
        check_pending();
        pend = 1'b0;
        op_valid = 1'b0;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule